// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This unit settles conditional branches while the branch is still in the decode stage of a five-stage, 32-bit in-order pipeline. Each cycle it receives the instruction word now in decode, the PC of that instruction plus one instruction width, and the two source operands that the register file returned during decode. It sign-extends the 16-bit offset and scales it to a byte offset. It adds the result to the incremented PC to form a target. It then evaluates the branch condition with an equality comparator rather than the ALU.

The unit owns the fetch PC register. When no branch is taken, the PC steps forward by one instruction width (4 bytes). When a branch is taken, the target is loaded at the clock edge that closes decode, so the fetch stage reads from the new address in the very next cycle.

The instruction fetched during the branch's decode cycle is the one in the shadow of the branch. A build-time parameter decides how it is treated. In flush mode the unit raises a one-cycle squash while that instruction sits in decode, so it is discarded and cannot redirect fetch. In delay-slot mode it always executes and is resolved like any other instruction.

Top module: `bru_top`

## Requirements
- R1: While `rst` is high at a clock edge, `fetch_pc` becomes `RESET_PC` (default 0x1000) and `redirect` and `squash` become 0.
- R2: After a cycle that took no branch, `fetch_pc` equals its previous value plus 4 and `redirect` is 0.
- R3: After a cycle that took a branch, `redirect` is 1 and `fetch_pc` equals `id_pc_inc` + (sign-extended `id_instr[15:0]` shifted left by 2), computed modulo 2^32.
- R4: Opcode 6'h04 in `id_instr[31:26]` (branch-if-equal) is taken when `id_rs_val == id_rt_val`, or when the source index fields `id_instr[25:21]` and `id_instr[20:16]` are identical.
- R5: Opcode 6'h05 (branch-if-not-equal) is taken exactly when the R4 equality does not hold.
- R6: Opcode 6'h06 is taken when `id_rs_val` is zero, and opcode 6'h07 is taken when `id_rs_val` is nonzero. In both cases `id_rt_val` has no effect.
- R7: Any other opcode, and any cycle with `id_valid` low, takes no branch.
- R8: In flush mode (`DELAY_SLOT`=0), `squash` is 1 for exactly the one cycle that follows a taken branch, and is 0 otherwise.
- R9: In flush mode, an instruction presented while `squash` is high takes no branch, even when it is a branch whose condition holds.
- R10: In delay-slot mode (`DELAY_SLOT`=1), `squash` stays 0 and the instruction after a taken branch is resolved normally, so a branch there can redirect again.
- R11: An offset with bit 15 set yields a target below `id_pc_inc`, and the addition wraps past address zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_instr | input | 32 | Instruction word in decode |
| id_pc_inc | input | 32 | PC of the decode instruction plus 4 |
| id_rs_val | input | 32 | First source operand read in decode |
| id_rt_val | input | 32 | Second source operand read in decode |
| fetch_pc | output | 32 | Address the fetch stage uses this cycle |
| redirect | output | 1 | fetch_pc was loaded from a branch target |
| squash | output | 1 | Discard the instruction now in decode (flush mode only) |

## Verification
Random cycles mix the four branch opcodes with other opcodes and idle slots. Operand pairs are drawn as identical, as all-zero, or as unrelated values, so the equal, not-equal and zero tests all see both outcomes. Some cycles repeat the same source index, which exercises the index-match shortcut on its own. Directed sequences place a taken branch directly after another taken branch. This is where flush mode and delay-slot mode must differ, since the second branch must be killed in one mode and honoured in the other. Other directed cases use offsets of extreme sign that wrap below address zero, and confirm that a zero test ignores the second operand.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam logic [5:0] OPC_BR_EQ  = 6'h04;
  localparam logic [5:0] OPC_BR_NE  = 6'h05;
  localparam logic [5:0] OPC_BR_EQZ = 6'h06;
  localparam logic [5:0] OPC_BR_NEZ = 6'h07;

  typedef enum logic [2:0] {
    BK_NONE = 3'd0,
    BK_EQ   = 3'd1,
    BK_NE   = 3'd2,
    BK_EQZ  = 3'd3,
    BK_NEZ  = 3'd4
  } br_kind_e;
endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
#(
  parameter int INSN_W = 32,
  parameter int OPC_W  = 6,
  parameter int IDX_W  = 5,
  parameter int RS_LSB = 21,
  parameter int RT_LSB = 16,
  parameter int IMM_W  = 16
) (
  input  logic              valid,
  input  logic              kill,
  input  logic [INSN_W-1:0] instr,
  output br_kind_e          kind,
  output logic              idx_same,
  output logic [IMM_W-1:0]  imm
);
  logic [OPC_W-1:0] opc;
  logic [IDX_W-1:0] rs_idx;
  logic [IDX_W-1:0] rt_idx;

  assign opc      = instr[INSN_W-1 -: OPC_W];
  assign rs_idx   = instr[RS_LSB +: IDX_W];
  assign rt_idx   = instr[RT_LSB +: IDX_W];
  assign imm      = instr[IMM_W-1:0];
  assign idx_same = (rs_idx == rt_idx);

  always_comb begin
    kind = BK_NONE;
    if (valid && !kill) begin
      case (opc)
        OPC_W'(OPC_BR_EQ):  kind = BK_EQ;
        OPC_W'(OPC_BR_NE):  kind = BK_NE;
        OPC_W'(OPC_BR_EQZ): kind = BK_EQZ;
        OPC_W'(OPC_BR_NEZ): kind = BK_NEZ;
        default:            kind = BK_NONE;
      endcase
    end
  end
endmodule

// File: rtl/bru_target.sv
module bru_target #(
  parameter int XLEN     = 32,
  parameter int IMM_W    = 16,
  parameter int ALIGN_SH = 2
) (
  input  logic [XLEN-1:0]  pc_inc,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  target
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] imm_sx;
  logic [XLEN-1:0] byte_off;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign imm_sx = imm[XLEN-1:0];
    end
  endgenerate

  assign byte_off = imm_sx << ALIGN_SH;
  assign target   = pc_inc + byte_off;
endmodule

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  br_kind_e        kind,
  input  logic            idx_same,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            take
);
  logic same;
  logic a_zero;

  assign same   = idx_same | (a == b);
  assign a_zero = ~|a;

  always_comb begin
    case (kind)
      BK_EQ:   take = same;
      BK_NE:   take = ~same;
      BK_EQZ:  take = a_zero;
      BK_NEZ:  take = ~a_zero;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/bru_pc_reg.sv
module bru_pc_reg #(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] RESET_PC   = '0,
  parameter int              STEP       = 4,
  parameter bit              DELAY_SLOT = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] fetch_pc,
  output logic            redirect,
  output logic            squash
);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_pc <= RESET_PC;
      redirect <= 1'b0;
    end else begin
      fetch_pc <= take ? target : fetch_pc + STEP_V;
      redirect <= take;
    end
  end

  generate
    if (DELAY_SLOT) begin : g_slot
      assign squash = 1'b0;
    end else begin : g_flush
      logic sq_q;
      always_ff @(posedge clk) begin
        if (rst) sq_q <= 1'b0;
        else     sq_q <= take;
      end
      assign squash = sq_q;
    end
  endgenerate
endmodule

// File: rtl/bru_top.sv
module bru_top
  import bru_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              INSN_W     = 32,
  parameter int              OPC_W      = 6,
  parameter int              IDX_W      = 5,
  parameter int              RS_LSB     = 21,
  parameter int              RT_LSB     = 16,
  parameter int              IMM_W      = 16,
  parameter logic [XLEN-1:0] RESET_PC   = 32'h0000_1000,
  parameter bit              DELAY_SLOT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_valid,
  input  logic [INSN_W-1:0] id_instr,
  input  logic [XLEN-1:0]   id_pc_inc,
  input  logic [XLEN-1:0]   id_rs_val,
  input  logic [XLEN-1:0]   id_rt_val,
  output logic [XLEN-1:0]   fetch_pc,
  output logic              redirect,
  output logic              squash
);
  localparam int STEP     = INSN_W / 8;
  localparam int ALIGN_SH = $clog2(STEP);

  br_kind_e         kind;
  logic             idx_same;
  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  target;
  logic             take;
  logic             kill;

  generate
    if (DELAY_SLOT) begin : g_keep_slot
      assign kill = 1'b0;
    end else begin : g_kill_slot
      assign kill = squash;
    end
  endgenerate

  bru_decode #(
    .INSN_W(INSN_W), .OPC_W(OPC_W), .IDX_W(IDX_W),
    .RS_LSB(RS_LSB), .RT_LSB(RT_LSB), .IMM_W(IMM_W)
  ) u_dec (
    .valid(id_valid), .kill(kill), .instr(id_instr),
    .kind(kind), .idx_same(idx_same), .imm(imm)
  );

  bru_target #(.XLEN(XLEN), .IMM_W(IMM_W), .ALIGN_SH(ALIGN_SH)) u_tgt (
    .pc_inc(id_pc_inc), .imm(imm), .target(target)
  );

  bru_cond #(.XLEN(XLEN)) u_cond (
    .kind(kind), .idx_same(idx_same), .a(id_rs_val), .b(id_rt_val), .take(take)
  );

  bru_pc_reg #(
    .XLEN(XLEN), .RESET_PC(RESET_PC), .STEP(STEP), .DELAY_SLOT(DELAY_SLOT)
  ) u_pc (
    .clk(clk), .rst(rst), .take(take), .target(target),
    .fetch_pc(fetch_pc), .redirect(redirect), .squash(squash)
  );
endmodule

// File: rtl/bru_checker.sv
module bru_checker
  import bru_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_W     = 32,
  parameter int OPC_W      = 6,
  parameter int IDX_W      = 5,
  parameter int RS_LSB     = 21,
  parameter int RT_LSB     = 16,
  parameter int IMM_W      = 16,
  parameter bit DELAY_SLOT = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              id_valid,
  input logic [INSN_W-1:0] id_instr,
  input logic [XLEN-1:0]   id_pc_inc,
  input logic [XLEN-1:0]   id_rs_val,
  input logic [XLEN-1:0]   id_rt_val,
  input logic [XLEN-1:0]   fetch_pc,
  input logic              redirect,
  input logic              squash
);
  localparam int SH = $clog2(INSN_W / 8);

  logic [OPC_W-1:0] opc;
  logic             eq_ops;
  logic             is_br;
  logic [XLEN-1:0]  want_tgt;
  logic             armed;

  assign opc    = id_instr[INSN_W-1 -: OPC_W];
  assign eq_ops = (id_rs_val == id_rt_val) ||
                  (id_instr[RS_LSB +: IDX_W] == id_instr[RT_LSB +: IDX_W]);
  assign is_br  = (opc == OPC_W'(OPC_BR_EQ)) || (opc == OPC_W'(OPC_BR_NE)) ||
                  (opc == OPC_W'(OPC_BR_EQZ)) || (opc == OPC_W'(OPC_BR_NEZ));
  assign want_tgt = id_pc_inc +
                    (XLEN'($signed(id_instr[IMM_W-1:0])) << SH);

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (armed && !redirect) |-> (fetch_pc == $past(fetch_pc) + XLEN'(INSN_W / 8)));

  p_target_load_r3: assert property (@(posedge clk) disable iff (rst)
    (id_valid && !squash && opc == OPC_W'(OPC_BR_EQ) && eq_ops) |=>
      (redirect && fetch_pc == $past(want_tgt)));

  p_ne_skip_r5: assert property (@(posedge clk) disable iff (rst)
    (id_valid && opc == OPC_W'(OPC_BR_NE) && eq_ops) |=> !redirect);

  p_zero_test_r6: assert property (@(posedge clk) disable iff (rst)
    (id_valid && !squash && opc == OPC_W'(OPC_BR_EQZ) && id_rs_val == '0) |=> redirect);

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!id_valid || !is_br) |=> !redirect);

  p_squash_pair_r8: assert property (@(posedge clk) disable iff (rst)
    squash |-> redirect);

  p_shadow_kill_r9: assert property (@(posedge clk) disable iff (rst)
    squash |=> (!squash && !redirect));

  generate
    if (DELAY_SLOT) begin : g_ds_chk
      p_no_squash_r10: assert property (@(posedge clk) disable iff (rst)
        redirect |-> !squash);
    end
  endgenerate
endmodule

bind bru_top bru_checker #(
  .XLEN(XLEN), .INSN_W(INSN_W), .OPC_W(OPC_W), .IDX_W(IDX_W),
  .RS_LSB(RS_LSB), .RT_LSB(RT_LSB), .IMM_W(IMM_W), .DELAY_SLOT(DELAY_SLOT)
) u_chk (
  .clk(clk), .rst(rst), .id_valid(id_valid), .id_instr(id_instr),
  .id_pc_inc(id_pc_inc), .id_rs_val(id_rs_val), .id_rt_val(id_rt_val),
  .fetch_pc(fetch_pc), .redirect(redirect), .squash(squash)
);

// File: tb/tb_bru_top.sv
`timescale 1ns/1ps
module tb_bru_top;
  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        id_valid = 1'b0;
  logic [31:0] id_instr = '0;
  logic [31:0] id_pc_inc = '0;
  logic [31:0] id_rs_val = '0;
  logic [31:0] id_rt_val = '0;
  logic [31:0] pc_f, pc_d;
  logic        rd_f, rd_d, sq_f, sq_d;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [31:0] m_pc [2];
  logic        m_rd [2];
  logic        m_sq [2];

  always #2 clk = ~clk;

  bru_top #(.RESET_PC(RST_PC), .DELAY_SLOT(1'b0)) dut (
    .clk(clk), .rst(rst), .id_valid(id_valid), .id_instr(id_instr),
    .id_pc_inc(id_pc_inc), .id_rs_val(id_rs_val), .id_rt_val(id_rt_val),
    .fetch_pc(pc_f), .redirect(rd_f), .squash(sq_f));

  bru_top #(.RESET_PC(RST_PC), .DELAY_SLOT(1'b1)) dut_ds (
    .clk(clk), .rst(rst), .id_valid(id_valid), .id_instr(id_instr),
    .id_pc_inc(id_pc_inc), .id_rs_val(id_rs_val), .id_rt_val(id_rt_val),
    .fetch_pc(pc_d), .redirect(rd_d), .squash(sq_d));

  function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                     logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic exp_take(logic [31:0] ins, logic [31:0] a, logic [31:0] b);
    logic same;
    same = (a == b) || (ins[25:21] == ins[20:16]);
    case (ins[31:26])
      6'h04:   return same;
      6'h05:   return !same;
      6'h06:   return a == 32'd0;
      6'h07:   return a != 32'd0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_tgt(logic [31:0] pci, logic [15:0] imm);
    logic [31:0] sx;
    sx = {{16{imm[15]}}, imm};
    return pci + (sx * 32'd4);
  endfunction

  function automatic string tag_of(logic v, logic [31:0] ins);
    if (!v) return "R7";
    case (ins[31:26])
      6'h04:   return "R4";
      6'h05:   return "R5";
      6'h06, 6'h07: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    string t_pc;
    t_pc = m_rd[0] ? "R3" : "R2";
    chk(tag, "flush redirect", {31'd0, rd_f}, {31'd0, m_rd[0]});
    chk(t_pc, "flush fetch_pc", pc_f, m_pc[0]);
    chk("R8", "flush squash", {31'd0, sq_f}, {31'd0, m_sq[0]});
    chk(tag, "slot redirect", {31'd0, rd_d}, {31'd0, m_rd[1]});
    chk(m_rd[1] ? "R3" : "R2", "slot fetch_pc", pc_d, m_pc[1]);
    chk("R10", "slot squash", {31'd0, sq_d}, {31'd0, m_sq[1]});
  endtask

  task automatic cycle(string tag, logic v, logic [31:0] ins, logic [31:0] pci,
                       logic [31:0] a, logic [31:0] b);
    rst = 1'b0;
    id_valid = v; id_instr = ins; id_pc_inc = pci; id_rs_val = a; id_rt_val = b;
    for (int m = 0; m < 2; m++) begin
      logic kill, tk;
      kill = (m == 0) && m_sq[0];
      tk = v && !kill && exp_take(ins, a, b);
      m_pc[m] = tk ? exp_tgt(pci, ins[15:0]) : m_pc[m] + 32'd4;
      m_rd[m] = tk;
      m_sq[m] = tk && (m == 0);
    end
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset fetch_pc", pc_f, RST_PC);
    chk("R1", "reset redirect", {31'd0, rd_f}, 32'd0);
    chk("R1", "reset squash", {31'd0, sq_f}, 32'd0);
    chk("R1", "reset slot fetch_pc", pc_d, RST_PC);
    for (int m = 0; m < 2; m++) begin
      m_pc[m] = RST_PC; m_rd[m] = 1'b0; m_sq[m] = 1'b0;
    end

    // R2: idle advance
    cycle("R7", 1'b0, mk(6'h04, 5'd1, 5'd2, 16'h0010), 32'h1004, 32'd5, 32'd5);
    cycle("R7", 1'b1, mk(6'h00, 5'd1, 5'd1, 16'h0010), 32'h1008, 32'd5, 32'd5);
    // R4 + R3: forward taken branch
    cycle("R4", 1'b1, mk(6'h04, 5'd1, 5'd2, 16'h0010), 32'h100C, 32'd7, 32'd7);
    // R9/R10: taken branch in the shadow, killed in flush mode only
    cycle("R9", 1'b1, mk(6'h05, 5'd3, 5'd4, 16'h0020), 32'h1050, 32'd1, 32'd2);
    cycle("R5", 1'b1, mk(6'h05, 5'd3, 5'd4, 16'h0020), 32'h1100, 32'd9, 32'd9);
    // R11: negative offset wrapping below zero
    cycle("R11", 1'b1, mk(6'h06, 5'd0, 5'd9, 16'hFFF0), 32'h0000_0010, 32'd0, 32'hDEAD);
    cycle("R7", 1'b0, 32'd0, 32'd0, 32'd0, 32'd0);
    chk("R11", "wrapped target", pc_f, m_pc[0]);
    // R6: second operand ignored by zero tests
    cycle("R6", 1'b1, mk(6'h07, 5'd2, 5'd2, 16'h0004), 32'h2000, 32'd0, 32'd0);
    cycle("R6", 1'b1, mk(6'h06, 5'd2, 5'd5, 16'h0004), 32'h2000, 32'd3, 32'd0);
    // R4: matching indices with different values
    cycle("R4", 1'b1, mk(6'h04, 5'd6, 5'd6, 16'h8000), 32'h3000, 32'd1, 32'd2);
    // R7: invalid slot holding a taken-looking branch
    cycle("R7", 1'b0, mk(6'h04, 5'd1, 5'd1, 16'h0001), 32'h4000, 32'd1, 32'd1);
    cycle("R7", 1'b1, mk(6'h3F, 5'd1, 5'd1, 16'h0001), 32'h4000, 32'd1, 32'd1);

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] op;
      logic v;
      logic [31:0] a, b;
      int sel;
      sel = int'($urandom % 6);
      v = (sel != 5);
      case (sel)
        0: op = 6'h04;
        1: op = 6'h05;
        2: op = 6'h06;
        3: op = 6'h07;
        default: op = 6'($urandom);
      endcase
      a = $urandom;
      case ($urandom % 4)
        0: b = a;
        1: begin a = 32'd0; b = ($urandom % 2 == 0) ? 32'd0 : $urandom; end
        default: b = $urandom;
      endcase
      begin
        logic [31:0] ins;
        ins = mk(op, 5'($urandom), 5'($urandom), 16'($urandom));
        cycle(tag_of(v, ins), v, ins, $urandom & 32'hFFFF_FFFC, a, b);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule